// File: doc/BRIEF.md
# Handshaked Byte Link, Peripheral Side

This block is the peripheral end of a byte-wide link between a host processor and a system-management controller. The host drives two active-low handshake lines, a busy (transfer-in-progress) line and an acknowledge line. The peripheral drives one active-low request line that tells the host response data is waiting. Each byte moves through an 8-bit shift-data value. No clock or strobe marks a byte on the link. Instead, any change of the busy/acknowledge pair since the previous cycle advances the transfer by one byte. A direction input selects whether the host is sending command bytes or collecting response bytes.

Bytes sent by the host are gathered into a command buffer. When the host releases busy, the block reports a completed packet and its length, and the buffer can be read by address. Response bytes are written into a response buffer by the controller logic and handed over with a commit. The host then pulls them out one per handshake edge. Every handshake event schedules a shift-register interrupt. The interrupt is a one-cycle pulse that comes out a fixed number of cycles later. Scheduling it again restarts the wait.

Top module: `hs_byte_link`

## Requirements
- R1: Out of reset, `dev_req_n` is 1, `sr_irq` and `pkt_valid` are 0, `sr_out` and `pkt_len` are 0, and both the command count and the pending response count are zero.
- R2: With `host_busy_n` low and `dir_to_host` 0, each cycle where {`host_busy_n`,`host_ack_n`} differs from its value in the previous cycle stores `sr_in` into the next command slot and schedules an interrupt. This includes the cycle where busy first falls.
- R3: Once the command buffer holds DEPTH bytes, further incoming bytes are dropped, no interrupt is scheduled for them, and the stored bytes do not change.
- R4: With `host_busy_n` low, `dir_to_host` 1 and response bytes pending, each change of the busy/acknowledge pair places the next response byte, in address order from 0, on `sr_out` and schedules an interrupt. With nothing pending, a change has no effect.
- R5: On the edge that places the last pending response byte on `sr_out`, `dev_req_n` goes high.
- R6: While busy is high in both this and the previous cycle, each toggle of `host_ack_n` sets `dev_req_n` low if response bytes are pending and high otherwise, and schedules an interrupt.
- R7: When `host_busy_n` rises, an interrupt is scheduled and `dev_req_n` goes low if response bytes are pending (otherwise it keeps its value). If at least one command byte was collected, `pkt_valid` pulses for one cycle with `pkt_len` equal to the count. The count then clears.
- R8: `sr_irq` is a one-cycle pulse that is high in the cycle after the DELAY_CYC-th clock edge following the scheduling edge. A new schedule before then restarts the wait, so only one pulse results.
- R9: `resp_we` writes `resp_wdata` at `resp_waddr`. `resp_commit` makes min(`resp_len`, DEPTH) bytes pending from address 0 and schedules an interrupt.
- R10: `cmd_rdata` shows the command byte stored at `cmd_raddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_busy_n | input | 1 | Transfer-in-progress from host, active low |
| host_ack_n | input | 1 | Acknowledge from host, active low |
| dir_to_host | input | 1 | 1: peripheral-to-host, 0: host-to-peripheral |
| sr_in | input | 8 | Shift-data value written by the host |
| dev_req_n | output | 1 | Data-pending request to host, active low |
| sr_out | output | 8 | Response byte presented to the host |
| sr_irq | output | 1 | Delayed shift-register interrupt pulse |
| pkt_valid | output | 1 | One-cycle pulse: a command packet completed |
| pkt_len | output | ADDR_W+1 | Byte count of the completed packet |
| cmd_raddr | input | ADDR_W | Command buffer read address |
| cmd_rdata | output | 8 | Command buffer read data |
| resp_we | input | 1 | Response buffer write enable |
| resp_waddr | input | ADDR_W | Response buffer write address |
| resp_wdata | input | 8 | Response buffer write data |
| resp_commit | input | 1 | Start a response of resp_len bytes |
| resp_len | input | 8 | Response length, clamped to DEPTH |

## Verification
The bench goes after the byte stored on the busy falling edge itself. A design that counted only acknowledge toggles would lose the first command byte and report a packet one short. It also overfills the command buffer. A design without the limit check would wrap and overwrite slot 0, or keep raising interrupts for dropped bytes. On the response side, it checks that the request line rises exactly with the last byte rather than one byte late, that an oversized commit is clamped, and that a busy rise with data still pending pulls the request low again. Two interrupt sources are placed closer together than the delay, to catch a timer that does not restart and so fires twice or early.

// File: rtl/hs_link_pkg.sv
// Shared types for the handshaked byte link.
package hs_link_pkg;

    typedef logic [7:0] byte_t;

    // Handshake events decoded from one cycle of line samples.
    typedef struct packed {
        logic active;      // busy line asserted (low) this cycle
        logic changed;     // busy/ack pair differs from previous cycle
        logic idle_toggle; // ack toggled while busy stayed deasserted
        logic xfer_end;    // busy line rose this cycle
    } hs_evt_t;

endpackage

// File: rtl/hs_edge_sampler.sv
// Registers the previous busy/ack levels and decodes handshake events.
// Assumes host lines are already synchronous to clk. Both history bits
// reset to the idle (high) level so no event fires on release of reset.
module hs_edge_sampler
    import hs_link_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    busy_n,
    input  logic    ack_n,
    output hs_evt_t evt
);

    logic last_busy_n;
    logic last_ack_n;

    // Hold previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_busy_n <= 1'b1;
            last_ack_n  <= 1'b1;
        end else begin
            last_busy_n <= busy_n;
            last_ack_n  <= ack_n;
        end
    end

    // Decode events from current and previous levels.
    always_comb begin
        evt.active      = !busy_n;
        evt.changed     = (busy_n != last_busy_n) || (ack_n != last_ack_n);
        evt.idle_toggle = busy_n && last_busy_n && (ack_n != last_ack_n);
        evt.xfer_end    = busy_n && !last_busy_n;
    end

endmodule

// File: rtl/hs_cmd_collector.sv
// Collects host-to-peripheral bytes into a DEPTH-entry buffer and reports
// a packet when the transfer ends. Bytes beyond DEPTH are dropped.
// Assumes DEPTH is a power of two, at least 2.
module hs_cmd_collector
    import hs_link_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hs_evt_t           evt,
    input  logic              dir_to_host,
    input  byte_t             sr_in,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata,
    output logic [CNT_W-1:0]  count,
    output logic              stored,
    output logic              pkt_valid,
    output logic [CNT_W-1:0]  pkt_len
);

    byte_t            mem [DEPTH];
    logic [DEPTH-1:0] slot_we;

    // A byte is taken on a pair change in host-to-peripheral mode while room remains.
    always_comb begin
        stored = evt.active && !dir_to_host && evt.changed &&
                 (count < CNT_W'(DEPTH));
    end

    // Per-slot write enables and storage.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_comb begin
            slot_we[i] = stored && (count[ADDR_W-1:0] == ADDR_W'(i));
        end
        always_ff @(posedge clk) begin
            if (slot_we[i]) begin
                mem[i] <= sr_in;
            end
        end
    end

    // Fill count, cleared at the end of each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (evt.xfer_end) begin
            count <= '0;
        end else if (stored) begin
            count <= count + CNT_W'(1);
        end
    end

    // Packet report: one-cycle valid with the collected length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_valid <= 1'b0;
            pkt_len   <= '0;
        end else begin
            pkt_valid <= evt.xfer_end && (count != '0);
            if (evt.xfer_end && (count != '0)) begin
                pkt_len <= count;
            end
        end
    end

    // Asynchronous read port for the packet consumer.
    always_comb begin
        rdata = mem[raddr];
    end

endmodule

// File: rtl/hs_resp_streamer.sv
// Holds the response buffer, streams pending bytes to the host one per
// handshake change, and drives the active-low data-pending request.
// Assumes DEPTH <= 255 so an 8-bit length can express it.
module hs_resp_streamer
    import hs_link_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hs_evt_t           evt,
    input  logic              dir_to_host,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic              commit,
    input  logic [7:0]        len,
    output byte_t             sr_out,
    output logic              req_n,
    output logic              loaded
);

    byte_t            mem [DEPTH];
    logic [CNT_W-1:0] size;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] idx_nxt;
    logic [CNT_W-1:0] len_clamped;
    logic             pending;

    // Pending flag, next read index and clamped commit length.
    always_comb begin
        pending     = idx < size;
        idx_nxt     = idx + CNT_W'(1);
        len_clamped = (len > 8'(DEPTH)) ? CNT_W'(DEPTH) : CNT_W'(len);
        loaded      = evt.active && dir_to_host && evt.changed && pending;
    end

    // Response byte storage written by the controller side.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Length and read index; a commit overrides a concurrent load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size <= '0;
            idx  <= '0;
        end else if (commit) begin
            size <= len_clamped;
            idx  <= '0;
        end else if (loaded) begin
            idx <= idx_nxt;
        end
    end

    // Byte presented to the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_out <= '0;
        end else if (loaded) begin
            sr_out <= mem[idx[ADDR_W-1:0]];
        end
    end

    // Request line: released after the last byte, refreshed on idle toggles and transfer end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_n <= 1'b1;
        end else if (loaded) begin
            if (idx_nxt >= size) begin
                req_n <= 1'b1;
            end
        end else if (evt.idle_toggle) begin
            req_n <= !pending;
        end else if (evt.xfer_end && pending) begin
            req_n <= 1'b0;
        end
    end

endmodule

// File: rtl/hs_irq_delay.sv
// Delays each interrupt request by DELAY_CYC clock edges and emits a
// one-cycle pulse. A request during the wait restarts the count.
// Assumes DELAY_CYC >= 1.
module hs_irq_delay #(
    parameter int DELAY_CYC = 1000,
    parameter int CW        = $clog2(DELAY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sched,
    output logic irq
);

    logic [CW-1:0] remain;

    // Down-counter reloaded on every request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (sched) begin
            remain <= CW'(DELAY_CYC);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    // Pulse when the count expires without a fresh request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= !sched && (remain == CW'(1));
        end
    end

endmodule

// File: rtl/hs_byte_link.sv
// Peripheral side of a handshaked byte link. Host lines are sampled each
// cycle; command bytes are collected, response bytes are streamed, and
// every handshake event schedules a delayed shift-register interrupt.
// Assumes host lines are synchronous to clk; reset is synchronous, active low.
module hs_byte_link
    import hs_link_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DELAY_CYC = 1000,
    parameter int ADDR_W    = $clog2(DEPTH),
    parameter int CNT_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_busy_n,
    input  logic              host_ack_n,
    input  logic              dir_to_host,
    input  logic [7:0]        sr_in,
    output logic              dev_req_n,
    output logic [7:0]        sr_out,
    output logic              sr_irq,
    output logic              pkt_valid,
    output logic [CNT_W-1:0]  pkt_len,
    input  logic [ADDR_W-1:0] cmd_raddr,
    output logic [7:0]        cmd_rdata,
    input  logic              resp_we,
    input  logic [ADDR_W-1:0] resp_waddr,
    input  logic [7:0]        resp_wdata,
    input  logic              resp_commit,
    input  logic [7:0]        resp_len
);

    hs_evt_t          evt;
    logic             stored;
    logic             loaded;
    logic             sched;
    logic [CNT_W-1:0] rx_count;

    hs_edge_sampler u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_n (host_busy_n),
        .ack_n  (host_ack_n),
        .evt    (evt)
    );

    hs_cmd_collector #(.DEPTH(DEPTH)) u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .dir_to_host (dir_to_host),
        .sr_in       (sr_in),
        .raddr       (cmd_raddr),
        .rdata       (cmd_rdata),
        .count       (rx_count),
        .stored      (stored),
        .pkt_valid   (pkt_valid),
        .pkt_len     (pkt_len)
    );

    hs_resp_streamer #(.DEPTH(DEPTH)) u_stream (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .dir_to_host (dir_to_host),
        .we          (resp_we),
        .waddr       (resp_waddr),
        .wdata       (resp_wdata),
        .commit      (resp_commit),
        .len         (resp_len),
        .sr_out      (sr_out),
        .req_n       (dev_req_n),
        .loaded      (loaded)
    );

    // Every handshake event and every commit requests an interrupt.
    always_comb begin
        sched = stored || loaded || evt.idle_toggle || evt.xfer_end || resp_commit;
    end

    hs_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .sched (sched),
        .irq   (sr_irq)
    );

endmodule

// File: rtl/hs_link_checker.sv
// Property checker for hs_byte_link, attached by bind.
module hs_link_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_busy_n,
    input logic             dir_to_host,
    input logic [7:0]       sr_out,
    input logic             sr_irq,
    input logic             pkt_valid,
    input logic [CNT_W-1:0] pkt_len,
    input logic [CNT_W-1:0] rx_count
);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_irq |=> !sr_irq); // R8

    AST_PKT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid); // R7

    AST_PKT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != '0)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CNT_W'(DEPTH)); // R3

    AST_IDLE_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy_n |=> $stable(sr_out)); // R4

    AST_TX_NO_COLLECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_busy_n && dir_to_host) |=> $stable(rx_count)); // R2

endmodule

bind hs_byte_link hs_link_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_busy_n (host_busy_n),
    .dir_to_host (dir_to_host),
    .sr_out      (sr_out),
    .sr_irq      (sr_irq),
    .pkt_valid   (pkt_valid),
    .pkt_len     (pkt_len),
    .rx_count    (rx_count)
);

// File: tb/hs_byte_link_tb.sv
module hs_byte_link_tb;

    localparam int DEPTH  = 4;
    localparam int DELAY  = 6;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy_n = 1'b1, ack_n = 1'b1, dir = 1'b0;
    logic [7:0] sr_in = '0;
    logic req_n, irq, pkv;
    logic [7:0] sr_out, cmd_rdata;
    logic [CNT_W-1:0] pkl;
    logic [ADDR_W-1:0] cmd_raddr = '0, resp_waddr = '0;
    logic resp_we = 1'b0, commit = 1'b0;
    logic [7:0] resp_wdata = '0, resp_len = '0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    hs_byte_link #(.DEPTH(DEPTH), .DELAY_CYC(DELAY)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_busy_n(busy_n), .host_ack_n(ack_n),
        .dir_to_host(dir), .sr_in(sr_in), .dev_req_n(req_n), .sr_out(sr_out),
        .sr_irq(irq), .pkt_valid(pkv), .pkt_len(pkl), .cmd_raddr(cmd_raddr),
        .cmd_rdata(cmd_rdata), .resp_we(resp_we), .resp_waddr(resp_waddr),
        .resp_wdata(resp_wdata), .resp_commit(commit), .resp_len(resp_len)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    int m_lack, m_ltip, m_cnt, m_rsize, m_ridx, m_req, m_sr, m_irq, m_tmr, m_pkv, m_pkl;
    int m_cmd[DEPTH];
    int m_resp[DEPTH];
    bit model_live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lack = 1; m_ltip = 1; m_cnt = 0; m_rsize = 0; m_ridx = 0;
            m_req = 1; m_sr = 0; m_irq = 0; m_tmr = 0; m_pkv = 0; m_pkl = 0;
            model_live = 1;
        end else begin
            bit chg, pend, sch;
            chg  = (int'(ack_n) != m_lack) || (int'(busy_n) != m_ltip);
            pend = m_ridx < m_rsize;
            sch  = 0;
            m_pkv = 0;
            if (!busy_n) begin
                if (!dir) begin
                    if (chg && m_cnt < DEPTH) begin
                        m_cmd[m_cnt] = int'(sr_in); m_cnt++; sch = 1;
                    end
                end else if (chg && pend) begin
                    m_sr = m_resp[m_ridx]; m_ridx++;
                    if (m_ridx >= m_rsize) m_req = 1;
                    sch = 1;
                end
            end else begin
                if (m_ltip == 1 && int'(ack_n) != m_lack) begin
                    m_req = pend ? 0 : 1; sch = 1;
                end
                if (m_ltip == 0) begin
                    sch = 1;
                    if (pend) m_req = 0;
                    if (m_cnt > 0) begin m_pkv = 1; m_pkl = m_cnt; end
                    m_cnt = 0;
                end
            end
            if (resp_we) m_resp[resp_waddr] = int'(resp_wdata);
            if (commit) begin
                m_rsize = (resp_len > DEPTH) ? DEPTH : int'(resp_len);
                m_ridx = 0; sch = 1;
            end
            m_irq = (!sch && m_tmr == 1) ? 1 : 0;
            if (sch) m_tmr = DELAY; else if (m_tmr > 0) m_tmr--;
            m_lack = int'(ack_n); m_ltip = int'(busy_n);
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && model_live) begin
            chk(int'(req_n) == m_req,  "R5/R6/R7 dev_req_n", int'(req_n), m_req);
            chk(int'(sr_out) == m_sr,  "R4 sr_out", int'(sr_out), m_sr);
            chk(int'(irq) == m_irq,    "R8 sr_irq", int'(irq), m_irq);
            chk(int'(pkv) == m_pkv,    "R7 pkt_valid", int'(pkv), m_pkv);
            chk(int'(pkl) == m_pkl,    "R7 pkt_len", int'(pkl), m_pkl);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle_ack();
        @(negedge clk); ack_n = ~ack_n;
        wait_n(DELAY + 3);
    endtask

    task automatic set_busy(input logic v);
        @(negedge clk); busy_n = v;
        wait_n(DELAY + 3);
    endtask

    task automatic load_resp(input int n, input int base, input int len);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); resp_we = 1'b1; resp_waddr = ADDR_W'(i); resp_wdata = 8'(base + i);
        end
        @(negedge clk); resp_we = 1'b0; commit = 1'b1; resp_len = 8'(len);
        @(negedge clk); commit = 1'b0;
        wait_n(DELAY + 3);
    endtask

    task automatic read_cmd(input int a, input int exp, input string tag);
        @(negedge clk); cmd_raddr = ADDR_W'(a); #1;
        chk(int'(cmd_rdata) == exp, tag, int'(cmd_rdata), exp);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seen;
        wait_n(3);
        // R1: reset state
        chk(req_n === 1'b1, "R1 req_n reset", int'(req_n), 1);
        chk(irq === 1'b0 && pkv === 1'b0, "R1 irq/pkt reset", int'(irq) + int'(pkv), 0);
        chk(sr_out === 8'h00 && pkl === '0, "R1 sr_out/pkt_len reset", int'(sr_out), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_n(2);

        // R2: three command bytes, first on the busy falling edge
        dir = 1'b0;
        @(negedge clk); sr_in = 8'hA1; busy_n = 1'b0;
        wait_n(DELAY + 3);
        @(negedge clk); sr_in = 8'hB2; ack_n = 1'b0;
        wait_n(DELAY + 3);
        @(negedge clk); sr_in = 8'hC3; ack_n = 1'b1;
        wait_n(DELAY + 3);
        @(negedge clk); busy_n = 1'b1;
        @(negedge clk);
        chk(pkv === 1'b1 && pkl == 3, "R7 packet of 3", int'(pkl), 3);
        wait_n(DELAY + 2);
        read_cmd(0, 'hA1, "R2 R10 slot0");
        read_cmd(1, 'hB2, "R2 R10 slot1");
        read_cmd(2, 'hC3, "R2 R10 slot2");

        // R3: six bytes into a four-entry buffer
        @(negedge clk); sr_in = 8'h10; busy_n = 1'b0;
        wait_n(2);
        for (int i = 1; i < 6; i++) begin
            @(negedge clk); sr_in = 8'(8'h10 + i); ack_n = ~ack_n;
            wait_n(2);
        end
        @(negedge clk); busy_n = 1'b1;
        @(negedge clk);
        chk(pkl == DEPTH, "R3 overflow length", int'(pkl), DEPTH);
        wait_n(DELAY + 2);
        read_cmd(0, 'h10, "R3 slot0 kept");
        read_cmd(3, 'h13, "R3 slot3 kept");

        // R6 and R8: idle toggle with nothing pending, measure interrupt delay
        @(negedge clk); ack_n = ~ack_n;
        seen = 0;
        for (int k = 1; k <= DELAY + 4; k++) begin
            @(negedge clk);
            if (irq && seen == 0) seen = k;
        end
        chk(seen == DELAY + 1, "R8 interrupt delay", seen, DELAY + 1);
        chk(req_n === 1'b1, "R6 idle toggle nothing pending", int'(req_n), 1);

        // R9 and R6: commit three bytes, idle toggle asserts request
        load_resp(3, 'h50, 3);
        toggle_ack();
        chk(req_n === 1'b0, "R6 idle toggle pending", int'(req_n), 0);

        // R4 and R5: stream out
        dir = 1'b1;
        set_busy(1'b0);
        chk(sr_out == 8'h50, "R4 first byte", int'(sr_out), 'h50);
        toggle_ack();
        chk(sr_out == 8'h51 && req_n === 1'b0, "R4 second byte", int'(sr_out), 'h51);
        toggle_ack();
        chk(sr_out == 8'h52, "R4 third byte", int'(sr_out), 'h52);
        chk(req_n === 1'b1, "R5 request released on last byte", int'(req_n), 1);
        toggle_ack();
        chk(sr_out == 8'h52, "R4 no pending no change", int'(sr_out), 'h52);
        set_busy(1'b1);
        chk(req_n === 1'b1, "R7 end with nothing pending", int'(req_n), 1);

        // R7: busy rise with data pending pulls request low
        load_resp(2, 'h60, 2);
        dir = 1'b0;
        set_busy(1'b0);
        set_busy(1'b1);
        chk(req_n === 1'b0, "R7 end with pending", int'(req_n), 0);

        // R9: oversized commit clamps to DEPTH
        load_resp(DEPTH, 'h70, 9);
        dir = 1'b1;
        set_busy(1'b0);
        for (int i = 1; i < DEPTH; i++) toggle_ack();
        chk(sr_out == 8'(8'h70 + DEPTH - 1) && req_n === 1'b1, "R9 clamped length",
            int'(sr_out), 'h70 + DEPTH - 1);
        set_busy(1'b1);

        // R8: reschedule restarts the delay, one pulse only
        @(negedge clk); ack_n = ~ack_n;
        wait_n(3);
        @(negedge clk); ack_n = ~ack_n;
        seen = 0;
        for (int k = 1; k <= 2 * DELAY + 4; k++) begin
            @(negedge clk);
            if (irq) seen++;
        end
        chk(seen == 1, "R8 single pulse after restart", seen, 1);

        // R1: reset mid-response
        load_resp(2, 'h80, 2);
        toggle_ack();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(req_n === 1'b1, "R1 request after reset", int'(req_n), 1);
        @(negedge clk); rst_n = 1'b1;
        wait_n(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule